// File: doc/BRIEF.md
# Stepped Soft-Start Reference Generator

This block produces the digital reference code that a power converter's error amplifier uses as its target during start-up. When a start or restart request arrives, the reference climbs from zero to full scale (about 1.23 V) as a staircase of 127 equal steps of roughly 9.7 mV each. The whole climb lasts exactly 2047 oscillator cycles. The reference then stays at full scale until the next restart. A supervisor drives the restart pulse after the undervoltage lockout is released and after every fault recovery. It holds the block at zero while lockout is active.

The block counts oscillator ticks, which are single-cycle strobes synchronous to `clk`, in one cycle counter. The step index is the upper bits of that counter, so the index moves up once every 16 ticks. A small state machine sequences the ramp. It has three states: `SS_IDLE` (waiting at zero), `SS_RAMP` (counting ticks) and `SS_FULL` (ramp complete, held at full scale). It has four named transitions:
- START: `SS_IDLE` goes to `SS_RAMP` when restart is high and hold is low.
- RESTART: `SS_RAMP` or `SS_FULL` goes back to `SS_RAMP` with the counter cleared.
- FINISH: `SS_RAMP` goes to `SS_FULL` on the tick that takes the count from 2046 to 2047.
- LOCKOUT: any state goes to `SS_IDLE` while hold is high.

The reference code is the step index times a code step of 97, in units of 0.1 mV, which gives a full scale of 12319.

Top module: `soft_start_ref`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, step_idx is 0, ref_code is 0 and ramp_done is 0.
- R2: In the idle state, oscillator ticks change nothing. A restart pulse that arrives while hold is high is ignored. The ramp starts only on a restart pulse seen while hold is low.
- R3: During the ramp, each tick adds one to the cycle count. step_idx equals the number of ticks counted since the restart, divided by 16 and rounded down. It changes in the cycle right after the 16n-th tick is sampled.
- R4: ref_code always equals step_idx × 97, so 0 maps to 0 and step 127 maps to 12319.
- R5: step_idx reaches its maximum of 127 on the 2032nd tick after a restart and never goes higher.
- R6: ramp_done goes high right after the 2047th tick and not earlier. It then stays high with step_idx 127 and ref_code 12319, and further ticks change nothing.
- R7: A restart pulse while ramping or at full scale returns step_idx, ref_code and ramp_done to 0 in the next cycle. Counting then starts again from zero.
- R8: While hold is high, step_idx, ref_code and ramp_done read 0 in the same cycle and the counter is cleared. After hold falls, the block stays at zero until a restart pulse.
- R9: When a restart pulse and a tick arrive in the same cycle, the restart wins. That tick is not counted, so 16 further ticks are needed for step 1.
- R10: Apart from restart and hold, step_idx never decreases and rises by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator cycle |
| restart | input | 1 | One-cycle start or restart request from the supervisor |
| hold | input | 1 | Lockout level: forces zero and clears the ramp |
| step_idx | output | STEP_W (7) | Current staircase step, 0 to 127 |
| ref_code | output | CODE_W (14) | Reference code, step_idx × CODE_STEP |
| ramp_done | output | 1 | High once the full 2047-tick ramp is complete |

## Verification
The bench builds the block with its default parameters: an 11-bit cycle counter, a 7-bit step index and a code step of 97. With these, the exact 2032-tick and 2047-tick boundaries, the last-step length of 15 ticks and the full-scale code of 12319 are all reached in a few thousand clock cycles. Ticks are spaced two clocks apart. This keeps the complete ramp, repeated restarts and hold episodes well inside the run, and still separates tick edges from restart and hold edges.

// File: rtl/ss_ref_pkg.sv
package ss_ref_pkg;

    typedef enum logic [1:0] {
        SS_IDLE = 2'd0,
        SS_RAMP = 2'd1,
        SS_FULL = 2'd2
    } ss_state_e;

endpackage

// File: rtl/ss_ramp_counter.sv
module ss_ramp_counter #(
    parameter int CNT_W  = 11,
    parameter int STEP_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [STEP_W-1:0] step_o,
    output logic              near_top,
    output logic              at_top
);

    localparam logic [CNT_W-1:0] TOP     = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] TOP_M1  = TOP - 1'b1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (advance && !at_top) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        step_o   = cnt_q[CNT_W-1 -: STEP_W];
        near_top = (cnt_q == TOP_M1);
        at_top   = (cnt_q == TOP);
    end

endmodule

// File: rtl/ss_ramp_fsm.sv
module ss_ramp_fsm
    import ss_ref_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hold,
    input  logic      restart,
    input  logic      tick,
    input  logic      near_top,
    output ss_state_e state,
    output logic      clear_cnt,
    output logic      count_en
);

    ss_state_e state_q, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SS_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions: LOCKOUT, START/RESTART, FINISH
    always_comb begin
        state_nx = state_q;
        if (hold) begin
            state_nx = SS_IDLE;
        end else if (restart) begin
            state_nx = SS_RAMP;
        end else begin
            unique case (state_q)
                SS_IDLE: state_nx = SS_IDLE;
                SS_RAMP: state_nx = (tick && near_top) ? SS_FULL : SS_RAMP;
                SS_FULL: state_nx = SS_FULL;
                default: state_nx = SS_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        state     = state_q;
        clear_cnt = hold || restart;
        count_en  = (state_q == SS_RAMP) && tick && !hold && !restart;
    end

endmodule

// File: rtl/ss_code_map.sv
module ss_code_map #(
    parameter int STEP_W    = 7,
    parameter int CODE_STEP = 97,
    parameter int CODE_W    = 14
) (
    input  logic [STEP_W-1:0] step_i,
    output logic [CODE_W-1:0] code_o
);

    localparam bit POW2 = ((CODE_STEP & (CODE_STEP - 1)) == 0);

    generate
        if (POW2) begin : g_shift
            localparam int SH = $clog2(CODE_STEP);
            always_comb code_o = CODE_W'(step_i) << SH;
        end else begin : g_mult
            localparam logic [CODE_W-1:0] K = CODE_W'(CODE_STEP);
            always_comb code_o = CODE_W'(step_i) * K;
        end
    endgenerate

endmodule

// File: rtl/soft_start_ref.sv
module soft_start_ref
    import ss_ref_pkg::*;
#(
    parameter int CNT_W     = 11,
    parameter int STEP_W    = 7,
    parameter int CODE_STEP = 97,
    localparam int CODE_W   = $clog2(((1 << STEP_W) - 1) * CODE_STEP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              restart,
    input  logic              hold,
    output logic [STEP_W-1:0] step_idx,
    output logic [CODE_W-1:0] ref_code,
    output logic              ramp_done
);

    ss_state_e         state;
    logic              clear_cnt, count_en;
    logic              near_top, at_top;
    logic [STEP_W-1:0] cnt_step;
    logic [STEP_W-1:0] step_m;

    ss_ramp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .restart   (restart),
        .tick      (osc_tick),
        .near_top  (near_top),
        .state     (state),
        .clear_cnt (clear_cnt),
        .count_en  (count_en)
    );

    ss_ramp_counter #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear_cnt),
        .advance  (count_en),
        .step_o   (cnt_step),
        .near_top (near_top),
        .at_top   (at_top)
    );

    // hold masks the outputs in the same cycle
    always_comb begin
        step_m    = (hold || state == SS_IDLE) ? '0 : cnt_step;
        ramp_done = (state == SS_FULL) && at_top && !hold;
        step_idx  = step_m;
    end

    ss_code_map #(.STEP_W(STEP_W), .CODE_STEP(CODE_STEP), .CODE_W(CODE_W)) u_map (
        .step_i (step_m),
        .code_o (ref_code)
    );

endmodule

// File: rtl/ss_ref_checker.sv
module ss_ref_checker #(
    parameter int STEP_W    = 7,
    parameter int CODE_STEP = 97,
    parameter int CODE_W    = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              osc_tick,
    input logic              restart,
    input logic              hold,
    input logic [STEP_W-1:0] step_idx,
    input logic [CODE_W-1:0] ref_code,
    input logic              ramp_done
);

    localparam logic [STEP_W-1:0] STEP_MAX  = {STEP_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_FULL = CODE_W'(((1 << STEP_W) - 1) * CODE_STEP);

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |-> (step_idx == '0 && ref_code == '0 && !ramp_done));

    p_code_scale_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_done |-> (step_idx == STEP_MAX && ref_code == CODE_FULL));

    p_zero_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_idx == '0) |-> (ref_code == '0));

    p_no_tick_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !$past(osc_tick) && !$past(restart) && !$past(hold))
        |-> ($stable(step_idx) && $stable(ramp_done)));

    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && $past(ramp_done) && !$past(restart) && !$past(hold)) |-> ramp_done);

    p_restart_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && $past(restart)) |-> (step_idx == '0 && !ramp_done));

    p_hold_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (step_idx == '0 && ref_code == '0 && !ramp_done));

    p_step_monotone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !$past(hold) && !$past(restart))
        |-> (step_idx == $past(step_idx) || step_idx == $past(step_idx) + 1'b1));

endmodule

bind soft_start_ref ss_ref_checker #(
    .STEP_W    (STEP_W),
    .CODE_STEP (CODE_STEP),
    .CODE_W    (CODE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .restart   (restart),
    .hold      (hold),
    .step_idx  (step_idx),
    .ref_code  (ref_code),
    .ramp_done (ramp_done)
);

// File: tb/tb_soft_start_ref.sv
module tb_soft_start_ref;

    localparam int NV = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b0;
    logic        restart = 1'b0;
    logic        hold = 1'b0;
    logic [6:0]  step_idx;
    logic [13:0] ref_code;
    logic        ramp_done;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    soft_start_ref dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .restart   (restart),
        .hold      (hold),
        .step_idx  (step_idx),
        .ref_code  (ref_code),
        .ramp_done (ramp_done)
    );

    // vector: restart pulse, hold level, ticks, expected step, expected done
    localparam int    V_RS[NV]   = '{0, 1, 1, 0, 0, 0,    0,    0,  0, 0,  1, 0,  0,  1};
    localparam int    V_HD[NV]   = '{0, 1, 0, 0, 0, 0,    0,    0,  0, 0,  0, 1,  0,  0};
    localparam int    V_TK[NV]   = '{5, 3, 15, 1, 16, 1000, 1000, 14, 1, 50, 40, 20, 30, 33};
    localparam int    V_ST[NV]   = '{0, 0, 0, 1, 2, 64,   127,  127, 127, 127, 2, 0, 0, 2};
    localparam int    V_DN[NV]   = '{0, 0, 0, 0, 0, 0,    0,    0,  1, 1,  0, 0,  0,  0};
    localparam string V_RQ[NV]   = '{"R2", "R2", "R3", "R3", "R3", "R3", "R5", "R6",
                                     "R6", "R6", "R7", "R8", "R8", "R4"};

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_out(input string req, input int st, input int dn);
        chk(req, "step_idx", int'(step_idx), st);
        chk(req, "ref_code", int'(ref_code), st * 97);
        chk(req, "ramp_done", int'(ramp_done), dn);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) osc_tick = 1'b1;
            @(negedge clk) osc_tick = 1'b0;
        end
    endtask

    task automatic pulse_restart();
        @(negedge clk) restart = 1'b1;
        @(negedge clk) restart = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_out("R1", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1", 0, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk) hold = V_HD[v][0];
            if (V_RS[v] != 0) pulse_restart();
            ticks(V_TK[v]);
            @(negedge clk);
            check_out(V_RQ[v], V_ST[v], V_DN[v]);
        end

        // R9: restart and tick coincide, restart wins
        @(negedge clk) begin restart = 1'b1; osc_tick = 1'b1; end
        @(negedge clk) begin restart = 1'b0; osc_tick = 1'b0; end
        check_out("R9", 0, 0);
        ticks(15);
        @(negedge clk);
        check_out("R9", 0, 0);
        ticks(1);
        @(negedge clk);
        check_out("R9", 1, 0);

        // R7: restart from full scale
        ticks(2046);
        @(negedge clk);
        check_out("R6", 127, 1);
        pulse_restart();
        check_out("R7", 0, 0);

        // R1: reset mid-ramp, then idle ignores ticks (R2)
        ticks(40);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check_out("R1", 0, 0);
        rst_n = 1'b1;
        ticks(20);
        @(negedge clk);
        check_out("R2", 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule